// File: doc/BRIEF.md
# Half-Scratchpad Scrypt Mix Core

This block performs the memory-hard mixing stage of scrypt on a single 1024-bit block. A 1024-bit input block is presented on `blk_in` and `start` is strobed. The core first runs a fill phase, which walks the block through 1024 successive BlockMix steps. It then runs a read phase of 1024 steps. In each read step a scratchpad entry, chosen by the current block, is folded back in before the next BlockMix. When the last step completes, `done` pulses for one clock and the result is on `blk_out`.

The scratchpad is an on-chip register array of 1024-bit words, clocked together with the mix logic. Each access moves one whole block. Only the entries written at even fill steps are kept, so the array holds 512 words instead of 1024. A read phase access that targets an odd entry fetches the even entry just below it. It then passes that entry through BlockMix once more, which recreates the missing entry exactly. BlockMix is one combinational tree built from two Salsa20/8 cores in series, and it is evaluated once per clock. The read phase cannot look ahead, because every read index is taken from the block that the previous step produced.

Top module: `scrypt_half_pad_mix`

## Requirements
- R1: While reset is asserted and right after it, `busy` is 0, `done` is 0 and `blk_out` is all zeros.
- R2: Blocks are sixteen-plus-sixteen little-endian 32-bit words. Word k sits at bits [32k+31:32k]. The low half (words 0-15) is B0 and the high half (words 16-31) is B1. BlockMix returns Y0 in the low half and Y1 in the high half, where Y0 = Salsa20/8(B0 xor B1) and Y1 = Salsa20/8(Y0 xor B1). Salsa20/8 is four column/row double rounds with rotations 7, 9, 13 and 18, followed by adding the input words.
- R3: Fill phase: for steps i = 0..1023, the core stores X as entry i when i is even, then replaces X by BlockMix(X).
- R4: Read phase: for 1024 steps, the core takes j = (word 16 of X) mod 1024 and sets X = BlockMix(X xor V[j]). V[j] is the stored entry when j is even. When j is odd, V[j] is BlockMix of entry j-1. The final X appears on `blk_out` when `done` is high, and it equals a full-scratchpad computation of the same steps.
- R5: Let the edge that accepts `start` be edge 0, and let K be the number of odd indices j in the read phase. `done` rises after rising edge 3*1024 + K.
- R6: `busy` is 1 from the edge after acceptance until the run ends. It drops in the same cycle that `done` rises, and `blk_out` stays constant while the core is idle with no start.
- R7: `done` is high for exactly one clock per run.
- R8: A `start` given while `busy` is 1 is ignored. The running result and its latency are unchanged.
- R9: A `start` given in the cycle where `done` is high is accepted and begins a new run. `blk_out` holds the previous result during that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for mix logic and scratchpad |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run with `blk_in` when idle |
| blk_in | input | 1024 | Input block |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-clock pulse, result valid |
| blk_out | output | 1024 | Result block |

## Verification
The completion pulse and the acceptance of a fresh `start` can fall in the same cycle, because the core is already idle when `done` is high. The bench raises `start` with a new block in exactly the cycle where it sees `done`. It checks that `blk_out` still shows the first result in that cycle, that `busy` rises on the next edge, and that the second run returns its own reference result with the expected latency. A second case raises `start` with a different block partway through a run. The bench then checks that neither the result nor the cycle count changes.

// File: rtl/scrypt_mix_pkg.sv
package scrypt_mix_pkg;

    localparam int WORD_W     = 32;
    localparam int HALF_WORDS = 16;
    localparam int HALF_W     = WORD_W * HALF_WORDS;
    localparam int BLK_W      = 2 * HALF_W;

    typedef logic [WORD_W-1:0]                 word_t;
    typedef logic [HALF_WORDS-1:0][WORD_W-1:0] half_t;
    typedef logic [BLK_W-1:0]                  blk_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_REQ,
        ST_USE,
        ST_FIX
    } mix_state_e;

    // quarter-round lanes: four column groups, then four row groups (a, b, c, d)
    localparam int QR_TAB [8][4] = '{
        '{ 0,  4,  8, 12}, '{ 5,  9, 13,  1}, '{10, 14,  2,  6}, '{15,  3,  7, 11},
        '{ 0,  1,  2,  3}, '{ 5,  6,  7,  4}, '{10, 11,  8,  9}, '{15, 12, 13, 14}
    };

    function automatic word_t rotl(word_t x, int r);
        return (x << r) | (x >> (WORD_W - r));
    endfunction

    function automatic half_t quarter(half_t s, int a, int b, int c, int d);
        half_t t = s;
        t[b] = t[b] ^ rotl(t[a] + t[d], 7);
        t[c] = t[c] ^ rotl(t[b] + t[a], 9);
        t[d] = t[d] ^ rotl(t[c] + t[b], 13);
        t[a] = t[a] ^ rotl(t[d] + t[c], 18);
        return t;
    endfunction

    function automatic half_t double_round(half_t s);
        half_t t = s;
        for (int q = 0; q < 8; q++) begin
            t = quarter(t, QR_TAB[q][0], QR_TAB[q][1], QR_TAB[q][2], QR_TAB[q][3]);
        end
        return t;
    endfunction

endpackage

// File: rtl/mix_salsa.sv
module mix_salsa
    import scrypt_mix_pkg::*;
#(
    parameter int DROUNDS = 4
) (
    input  half_t din,
    output half_t dout
);

    half_t stage [DROUNDS+1];

    assign stage[0] = din;

    generate
        for (genvar r = 0; r < DROUNDS; r++) begin : g_dr
            assign stage[r+1] = double_round(stage[r]);
        end
        for (genvar w = 0; w < HALF_WORDS; w++) begin : g_add
            assign dout[w] = stage[DROUNDS][w] + din[w];
        end
    endgenerate

endmodule

// File: rtl/mix_block.sv
module mix_block
    import scrypt_mix_pkg::*;
#(
    parameter int DROUNDS = 4
) (
    input  blk_t din,
    output blk_t dout
);

    half_t lo_half;
    half_t hi_half;
    half_t y_lo;
    half_t y_hi;

    assign lo_half = din[HALF_W-1:0];
    assign hi_half = din[BLK_W-1:HALF_W];

    mix_salsa #(.DROUNDS(DROUNDS)) u_salsa_a (
        .din  (lo_half ^ hi_half),
        .dout (y_lo)
    );

    mix_salsa #(.DROUNDS(DROUNDS)) u_salsa_b (
        .din  (y_lo ^ hi_half),
        .dout (y_hi)
    );

    assign dout = {y_hi, y_lo};

endmodule

// File: rtl/mix_pad.sv
module mix_pad
    import scrypt_mix_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  blk_t          wdata,
    input  logic [AW-1:0] raddr,
    output blk_t          rdata
);

    blk_t mem [DEPTH];
    blk_t rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/scrypt_half_pad_mix.sv
module scrypt_half_pad_mix
    import scrypt_mix_pkg::*;
#(
    parameter int LOG_N   = 10,
    parameter int DROUNDS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [BLK_W-1:0] blk_in,
    output logic             busy,
    output logic             done,
    output logic [BLK_W-1:0] blk_out
);

    localparam int N         = 1 << LOG_N;
    localparam int PAD_DEPTH = N / 2;
    localparam int PAD_AW    = LOG_N - 1;
    localparam logic [LOG_N-1:0] CNT_ONE = LOG_N'(1);
    localparam int IDX_LSB   = HALF_W;

    typedef struct packed {
        mix_state_e       st;
        logic [LOG_N-1:0] cnt;
        blk_t             x;
        blk_t             v;
        logic             jodd;
        logic             done;
    } regs_t;

    regs_t r_q;
    regs_t r_d;

    blk_t              mix_in;
    blk_t              mix_out;
    blk_t              pad_rd;
    logic              pad_we;
    logic [PAD_AW-1:0] pad_waddr;
    logic [PAD_AW-1:0] pad_raddr;
    logic [LOG_N-1:0]  j_idx;
    logic              last_step;

    mix_block #(.DROUNDS(DROUNDS)) u_mix (
        .din  (mix_in),
        .dout (mix_out)
    );

    mix_pad #(.DEPTH(PAD_DEPTH)) u_pad (
        .clk   (clk),
        .we    (pad_we),
        .waddr (pad_waddr),
        .wdata (r_q.x),
        .raddr (pad_raddr),
        .rdata (pad_rd)
    );

    // read index: low LOG_N bits of word 16
    assign j_idx     = r_q.x[IDX_LSB +: LOG_N];
    assign last_step = &r_q.cnt;

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        pad_we    = 1'b0;
        pad_waddr = r_q.cnt[LOG_N-1:1];
        pad_raddr = j_idx[LOG_N-1:1];
        mix_in    = r_q.x;

        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.x   = blk_in;
                    r_d.cnt = '0;
                    r_d.st  = ST_FILL;
                end
            end
            ST_FILL: begin
                pad_we  = ~r_q.cnt[0];
                mix_in  = r_q.x;
                r_d.x   = mix_out;
                r_d.cnt = r_q.cnt + CNT_ONE;
                if (last_step) begin
                    r_d.st = ST_REQ;
                end
            end
            ST_REQ: begin
                r_d.jodd = j_idx[0];
                r_d.st   = ST_USE;
            end
            ST_USE: begin
                if (r_q.jodd) begin
                    mix_in = pad_rd;
                    r_d.v  = mix_out;
                    r_d.st = ST_FIX;
                end else begin
                    mix_in  = r_q.x ^ pad_rd;
                    r_d.x   = mix_out;
                    r_d.cnt = r_q.cnt + CNT_ONE;
                    if (last_step) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st = ST_REQ;
                    end
                end
            end
            ST_FIX: begin
                mix_in  = r_q.x ^ r_q.v;
                r_d.x   = mix_out;
                r_d.cnt = r_q.cnt + CNT_ONE;
                if (last_step) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.st = ST_REQ;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, x: '0, v: '0, jodd: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = (r_q.st != ST_IDLE);
    assign done    = r_q.done;
    assign blk_out = r_q.x;

endmodule

// File: rtl/scrypt_half_pad_mix_chk.sv
module scrypt_half_pad_mix_chk #(
    parameter int BW = 1024
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [BW-1:0] blk_out
);

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r6_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r9_start_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> (busy || done));

    a_r6_idle_output_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(blk_out));

endmodule

bind scrypt_half_pad_mix scrypt_half_pad_mix_chk #(.BW(1024)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .blk_out (blk_out)
);

// File: tb/scrypt_half_pad_mix_tb.sv
module scrypt_half_pad_mix_tb;

    localparam int CLK_P   = 10;
    localparam int N       = 1024;
    localparam int LOG_N   = 10;
    localparam int WAIT_MX = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1023:0] blk_in = '0;
    logic          busy;
    logic          done;
    logic [1023:0] blk_out;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit ended  = 1'b0;

    logic [1023:0] vfull [N];

    scrypt_half_pad_mix u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .blk_in  (blk_in),
        .busy    (busy),
        .done    (done),
        .blk_out (blk_out)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- reference model ----------------
    function automatic logic [31:0] rot(logic [31:0] v, int s);
        return (v << s) | (v >> (32 - s));
    endfunction

    function automatic logic [511:0] ref_salsa(logic [511:0] din);
        logic [31:0] w [16];
        logic [511:0] o;
        int a, b, c, d;
        for (int k = 0; k < 16; k++) w[k] = din[32*k +: 32];
        for (int dr = 0; dr < 4; dr++) begin
            for (int pass = 0; pass < 2; pass++) begin
                for (int k = 0; k < 4; k++) begin
                    if (pass == 0) begin
                        a = (5*k) % 16; b = (a+4) % 16; c = (a+8) % 16; d = (a+12) % 16;
                    end else begin
                        a = 5*k; b = 4*k + (k+1)%4; c = 4*k + (k+2)%4; d = 4*k + (k+3)%4;
                    end
                    w[b] = w[b] ^ rot(w[a] + w[d], 7);
                    w[c] = w[c] ^ rot(w[b] + w[a], 9);
                    w[d] = w[d] ^ rot(w[c] + w[b], 13);
                    w[a] = w[a] ^ rot(w[d] + w[c], 18);
                end
            end
        end
        for (int k = 0; k < 16; k++) o[32*k +: 32] = w[k] + din[32*k +: 32];
        return o;
    endfunction

    function automatic logic [1023:0] ref_bmix(logic [1023:0] x);
        logic [511:0] y0, y1;
        y0 = ref_salsa(x[511:0] ^ x[1023:512]);
        y1 = ref_salsa(y0 ^ x[1023:512]);
        return {y1, y0};
    endfunction

    function automatic logic [1023:0] ref_romix(logic [1023:0] b, output int odd_n);
        logic [1023:0] x;
        int j;
        x = b;
        odd_n = 0;
        for (int i = 0; i < N; i++) begin
            vfull[i] = x;
            x = ref_bmix(x);
        end
        for (int i = 0; i < N; i++) begin
            j = int'(x[512 +: LOG_N]);
            if (j % 2 == 1) odd_n++;
            x = ref_bmix(x ^ vfull[j]);
        end
        return x;
    endfunction

    // ---------------- helpers ----------------
    task automatic check(bit ok, string req, string what, logic [1023:0] act, logic [1023:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_all();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    function automatic logic [1023:0] rand_blk();
        logic [1023:0] v;
        for (int k = 0; k < 32; k++) v[32*k +: 32] = $urandom;
        return v;
    endfunction

    // called at a negedge; leaves the bench at the following negedge
    task automatic launch(logic [1023:0] b, output int cs);
        blk_in = b;
        start  = 1'b1;
        cs     = cyc;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R6", "busy after accept", 1024'(busy), 1024'(1));
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int k = 0; k < WAIT_MX; k++) begin
            if (done) begin
                seen = 1'b1;
                return;
            end
            @(negedge clk);
        end
        n_chk++;
        n_fail++;
        $display("FAIL R5 done never seen: actual 0 expected 1");
    endtask

    task automatic judge(string tag, logic [1023:0] exp, int odd_n, int cs);
        check(blk_out === exp, "R4", {tag, " result"}, blk_out, exp);
        check((cyc - cs) == 1 + 3*N + odd_n, "R5", {tag, " latency"},
              1024'(cyc - cs), 1024'(1 + 3*N + odd_n));
        check(busy == 1'b0, "R6", {tag, " busy low at done"}, 1024'(busy), 1024'(0));
    endtask

    task automatic full_run(string tag, logic [1023:0] b, bit poke);
        logic [1023:0] exp;
        int odd_n, cs;
        bit seen;
        exp = ref_romix(b, odd_n);
        @(negedge clk);
        launch(b, cs);
        if (poke) begin
            repeat (150) @(negedge clk);
            blk_in = ~b;
            start  = 1'b1;
            @(negedge clk);
            start  = 1'b0;
            repeat (1500) @(negedge clk);
            blk_in = b ^ {32{32'h5a5a_0001}};
            start  = 1'b1;
            @(negedge clk);
            start  = 1'b0;
        end
        wait_done(seen);
        if (!seen) finish_all();
        judge(poke ? {tag, " R8 ignored start"} : tag, exp, odd_n, cs);
        @(negedge clk);
        check(done == 1'b0, "R7", {tag, " done one cycle"}, 1024'(done), 1024'(0));
        check(blk_out === exp, "R6", {tag, " idle output held"}, blk_out, exp);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [1023:0] ba, bb, ea, eb;
        int oa, ob, cs;
        bit seen;

        void'($urandom(32'd7321));

        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1", "busy in reset", 1024'(busy), 1024'(0));
        check(done == 1'b0, "R1", "done in reset", 1024'(done), 1024'(0));
        check(blk_out === '0, "R1", "blk_out in reset", blk_out, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && blk_out === '0, "R1", "state after reset",
              {busy, done, blk_out[1021:0]}, '0);

        // R2 R3 R4: directed patterns, then random
        full_run("zero block", '0, 1'b0);
        full_run("ones block", '1, 1'b0);
        full_run("random A", rand_blk(), 1'b0);
        full_run("random B", rand_blk(), 1'b1);

        // R9: new start in the done cycle
        ba = rand_blk();
        bb = rand_blk();
        ea = ref_romix(ba, oa);
        @(negedge clk);
        launch(ba, cs);
        wait_done(seen);
        if (!seen) finish_all();
        judge("R9 first run", ea, oa, cs);
        check(blk_out === ea, "R9", "result held in done cycle", blk_out, ea);
        launch(bb, cs);
        cs = cs;
        check(done == 1'b0, "R7", "done dropped on restart", 1024'(done), 1024'(0));
        eb = ref_romix(bb, ob);
        wait_done(seen);
        if (!seen) finish_all();
        judge("R9 second run", eb, ob, cs);

        finish_all();
    end

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_all();
    end

endmodule